// File: doc/BRIEF.md
# SD Card Clock Generator with Glitch-Free Gating

This block derives the SD card clock from a single base clock. The divisor has two stages: a power-of-two prescale factor between 1 and 256, multiplied by a linear factor between 1 and 16. The card clock period is therefore the product of the two factors, counted in base-clock cycles.

Software reaches the block through a small write/read register port. The port holds a control word and a status word. A clean frequency change follows a fixed order:

1. Clear the card-clock output enable.
2. Write the new divisor fields.
3. Poll the settled flag in the status word.
4. Set the output enable again.

The output gate only opens or closes on a divided-period boundary, so the card pin never carries a truncated pulse. In divide-by-one mode the base clock itself is passed through an AND gate. That gate's enable is captured on the falling base-clock edge.

A divisor write clears the settled flag at once. The flag returns after two full divided periods. If software enables the output early, the pin stays low until the flag is back.

Top module: `sd_card_clkgen`

## Requirements
- R1: After reset the control word reads 0x80F0 (prescale field 0x80, linear field 0xF, all enable bits 0), the settled flag reads 0 and the card clock is low. The settled flag rises 8192 base cycles after reset is released.
- R2: The control word lives at address 0x2C and the status word at address 0x24. In the control word, bits 15:8 are the prescale field, bits 7:4 the linear field, bit 3 the card-clock output enable and bits 2:0 three auxiliary enable bits. In the status word, bit 3 is the settled flag and all other bits read 0. Any other address reads 0.
- R3: The card clock period is P*D base cycles. D is the linear field plus one. P is 1 for a prescale field of 0, and twice the field for a field of 1, 2, 4, ... 0x80.
- R4: For a divisor N of 2 or more, each card clock period is high for floor(N/2) base cycles and low for the rest. For N equal to 1, the card clock follows the base clock while running and is low while the base clock is low.
- R5: A control write that changes either divisor field makes the settled flag read 0 from the cycle after the write. The flag reads 1 again exactly 2N base cycles after the write edge, where N is the new divisor.
- R6: A control write that leaves both divisor fields unchanged does not disturb the settled flag.
- R7: Clearing the output enable during a high phase lets that pulse finish at full length. The card clock then stays low.
- R8: While the settled flag is 0 the card clock stays low, even with the output enable set. Once the flag rises with the enable set, a full-length pulse starts within N+1 cycles.
- R9: The first card clock pulse after enabling begins on a period boundary and is a full floor(N/2) cycles high.
- R10: The three auxiliary enable bits are stored and read back. They have no effect on the card clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| card_clk | output | 1 | Gated, divided card clock |

## Verification
The bench sweeps prescale values 1, 2, 4 and 8 against linear values 1, 3 and 6, and also runs the slowest reset setting. For each setting it measures both the settling delay and the high and low run lengths. Odd divisors are included because a design that rounds the high phase up instead of down would show a wrong high count. Divide-by-one is checked in both clock phases; a design that used a registered path there could not follow the base clock at all.

The bench also:
- disables the output in mid-pulse, to catch a gate that chops the pulse short;
- writes a new divisor with the enable already set, to catch a gate that lets pulses out before the settled flag returns;
- rewrites unchanged divisor fields, to catch a settle timer that restarts on every write.

// File: rtl/sd_card_clkgen.sv
module sd_card_clkgen #(
  parameter int               ADDR_W         = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS       = 8'h2C,
  parameter logic [ADDR_W-1:0] STAT_OFS       = 8'h24,
  parameter int               SETTLE_PERIODS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              card_clk
);
  localparam int PRE_W = 8;
  localparam int DIV_W = 4;
  localparam int N_W   = PRE_W + DIV_W + 1;
  localparam int SET_W = $clog2(SETTLE_PERIODS + 1);

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic             out_en_q;
  logic [2:0]       aux_q;
  logic             stable_q, run_q, card_q, en_fall_q;
  logic [N_W-1:0]   pos_q;
  logic [SET_W-1:0] settle_q;

  function automatic logic [3:0] pre_shift(input logic [PRE_W-1:0] f);
    logic [3:0] s;
    s = '0;
    for (int i = 0; i < PRE_W; i++)
      if (f[i]) s = 4'(i + 1);
    return s;
  endfunction

  logic           ctrl_wr, div_chg, wrap, want, run_nxt, n_one;
  logic [N_W-1:0] n_total, n_m1, half_n, pos_nxt;

  assign ctrl_wr = wr_en && (wr_addr == CTRL_OFS);
  assign div_chg = ctrl_wr && ((wr_data[15:8] != pre_q) || (wr_data[7:4] != div_q));
  assign n_total = {{(N_W-DIV_W-1){1'b0}}, ({1'b0, div_q} + 5'd1)} << pre_shift(pre_q);
  assign n_m1    = n_total - N_W'(1);
  assign half_n  = n_total >> 1;
  assign n_one   = (n_total == N_W'(1));
  assign wrap    = (pos_q == n_m1);
  assign pos_nxt = (div_chg || wrap) ? '0 : pos_q + N_W'(1);
  assign want    = out_en_q && stable_q && !div_chg;
  assign run_nxt = (pos_nxt == '0) ? want : run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= 8'h80;
      div_q    <= 4'hF;
      out_en_q <= 1'b0;
      aux_q    <= '0;
    end else if (ctrl_wr) begin
      pre_q    <= wr_data[15:8];
      div_q    <= wr_data[7:4];
      out_en_q <= wr_data[3];
      aux_q    <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      run_q <= 1'b0;
      card_q <= 1'b0;
    end else begin
      pos_q  <= pos_nxt;
      run_q  <= run_nxt;
      card_q <= run_nxt && (pos_nxt < half_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b0;
      settle_q <= '0;
    end else if (div_chg) begin
      stable_q <= 1'b0;
      settle_q <= '0;
    end else if (!stable_q && wrap) begin
      if (settle_q == SET_W'(SETTLE_PERIODS - 1)) stable_q <= 1'b1;
      else settle_q <= settle_q + SET_W'(1);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_fall_q <= 1'b0;
    else        en_fall_q <= run_q;
  end

  assign card_clk = n_one ? (clk & en_fall_q) : card_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_OFS)      rd_data = {pre_q, div_q, out_en_q, aux_q};
    else if (rd_addr == STAT_OFS) rd_data = {12'h000, stable_q, 3'b000};
  end

  AST_DIV_WRITE_DROPS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_chg |=> !stable_q); // R5
  AST_STABLE_RISES_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable_q) |-> $past(wrap)); // R5
  AST_UNSTABLE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !stable_q |=> !card_q); // R8
  AST_RISE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_q) |-> (pos_q == '0)); // R9
  AST_FALL_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(card_q) && !$past(div_chg)) |-> (pos_q == half_n)); // R4
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= n_m1); // R3
endmodule

// File: tb/sd_card_clkgen_bench.sv
module sd_card_clkgen_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTRL = 8'h2C;
  localparam logic [7:0] STAT = 8'h24;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = STAT;
  logic [15:0] wr_data = '0, rd_data;
  logic        card_clk;
  int checks = 0, fails = 0;
  int cur_pf = 8'h80, cur_df = 15;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_card_clkgen u_sd_card_clkgen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .card_clk(card_clk));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio(int pf, int df);
    return ((pf == 0) ? 1 : 2 * pf) * (df + 1);
  endfunction

  function automatic logic [15:0] word(int pf, int df, bit en, logic [2:0] aux);
    return {pf[7:0], df[3:0], en, aux};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk);
    wr_addr = CTRL; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic read_ctrl(output logic [15:0] v);
    rd_addr = CTRL; #1; v = rd_data; rd_addr = STAT; #1;
  endtask

  task automatic run_shape(int n, string req);
    int hi, lo, w;
    w = 0;
    while (card_clk !== 1'b1 && w <= n + 2) begin step(); w++; end
    check({req, " rise seen"}, (w <= n + 1) ? 1 : 0, 1);
    hi = 0;
    while (card_clk === 1'b1 && hi <= n) begin hi++; step(); end
    lo = 0;
    while (card_clk === 1'b0 && lo <= n) begin lo++; step(); end
    check({req, " high cycles"}, hi, n / 2);
    check({req, " period"}, hi + lo, n);
  endtask

  task automatic retune(int pf, int df);
    int n, j;
    wr(word(cur_pf, cur_df, 1'b0, 3'b000));
    repeat (ratio(cur_pf, cur_df) + 2) step();
    wr(word(pf, df, 1'b0, 3'b000));
    check("R5 flag cleared after divisor write", rd_data[3], 0);
    cur_pf = pf; cur_df = df;
    n = ratio(pf, df);
    for (j = 1; j <= 2 * n + 4; j++) begin
      step();
      if (rd_data[3]) break;
    end
    check("R5 settle delay", j, 2 * n);
  endtask

  task automatic enable_and_measure();
    int n;
    n = ratio(cur_pf, cur_df);
    wr(word(cur_pf, cur_df, 1'b1, 3'b000));
    if (n == 1) begin
      repeat (3) step();
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); #2;
        check("R4 div1 high phase", card_clk, 1);
        @(negedge clk); #2;
        check("R4 div1 low phase", card_clk, 0);
      end
    end else begin
      run_shape(n, "R9 first pulse");
      run_shape(n, "R3 R4 steady");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int j, hi, w;
    int pfs [4] = '{0, 1, 2, 4};
    int dfs [3] = '{0, 2, 5};
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flag", rd_data[3], 0);
    check("R1 reset card clock", card_clk, 0);
    read_ctrl(v);
    check("R1 R2 reset control word", v, 16'h80F0);
    rd_addr = 8'h10; #1;
    check("R2 unmapped reads 0", rd_data, 0);
    rd_addr = STAT; #1;
    check("R2 status other bits", rd_data & 16'hFFF7, 0);
    @(negedge clk); rst_n = 1'b1;
    j = 0;
    while (!rd_data[3] && j < 9000) begin step(); j++; end
    check("R1 first settle after reset", j, 8192);
    enable_and_measure();

    foreach (pfs[a]) foreach (dfs[b]) begin
      retune(pfs[a], dfs[b]);
      enable_and_measure();
    end

    retune(2, 1);
    enable_and_measure();
    w = 0;
    while (card_clk !== 1'b1 && w < 20) begin step(); w++; end
    hi = 1;
    wr(word(2, 1, 1'b0, 3'b000));
    while (card_clk === 1'b1 && hi < 20) begin hi++; step(); end
    check("R7 pulse finishes after disable", hi, 4);
    hi = 0;
    for (int k = 0; k < 24; k++) begin step(); if (card_clk) hi++; end
    check("R7 stays low after disable", hi, 0);

    wr(word(1, 2, 1'b1, 3'b000));
    cur_pf = 1; cur_df = 2;
    hi = 0;
    for (j = 1; j <= 20; j++) begin
      if (card_clk) hi++;
      step();
      if (rd_data[3]) break;
    end
    check("R8 low while unsettled", hi, 0);
    check("R8 settle with enable set", j, 12);
    run_shape(6, "R8 output after settle");

    wr(word(1, 2, 1'b1, 3'b101));
    for (int k = 0; k < 8; k++) begin
      check("R6 flag kept on same-divisor write", rd_data[3], 1);
      step();
    end
    read_ctrl(v);
    check("R10 aux bits read back", v, 16'h012D);
    run_shape(6, "R10 aux bits do not alter clock");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule